// File: doc/BRIEF.md
# Streaming Sobel Edge Thresholder

This block turns a grayscale image into a binary edge map as the image streams past. Pixels of 8 bits arrive one per accepted beat, row after row, left to right, over a valid/ready handshake. Two row stores keep the previous two rows. A sliding 3x3 neighbourhood is built from them and from the incoming pixel. A horizontal and a vertical weighted difference are formed from that neighbourhood. Their squares are summed, and the sum is compared against a programmable limit.

Each output beat carries either 255 (edge) or 0 (no edge), together with a frame-start flag and a row-end flag. The output stream runs W+1 pixels behind the input. After the last input pixel of a frame, the block emits the remaining border pixels on its own, and only then accepts the next frame. Image width and height are set at run time through configuration inputs, up to limits fixed by parameters. A stall on the output also stalls the input, and no pixel is lost.

Top module: `sobel_edge_stream`

## Requirements
- R1: The horizontal gradient of a window is (top-right + 2·middle-right + bottom-right) minus (top-left + 2·middle-left + bottom-left).
- R2: The vertical gradient of a window is (top-left + 2·top-centre + top-right) minus (bottom-left + 2·bottom-centre + bottom-right).
- R3: An interior output pixel is 255 when gx² + gy² is strictly greater than `cfg_thresh`, and 0 otherwise; equality gives 0.
- R4: Pixels in row 0, row H-1, column 0 and column W-1 are always emitted as 0.
- R5: Each frame of W×H input pixels yields exactly W×H output beats in raster order, and no beat beyond them.
- R6: `out_sof` is 1 only on the beat for pixel (0,0). `out_eol` is 1 exactly on the beat for column W-1 of every row.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output beat is held unchanged and `in_ready` is 0, so no data is dropped.
- R8: `cfg_width` and `cfg_height` set the frame size at run time, from 3 up to MAX_W and MAX_H. They are held stable during a frame, and successive frames may use different sizes.
- R9: Every output pixel value is either 0 or 255.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | $clog2(MAX_W+1) | Image width in pixels |
| cfg_height | input | $clog2(MAX_H+1) | Image height in rows |
| cfg_thresh | input | 21 | Limit that the squared gradient sum must exceed |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel |
| in_pixel | input | 8 | Grayscale input pixel |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_pixel | output | 8 | Edge value, 0 or 255 |
| out_sof | output | 1 | Beat is pixel (0,0) of a frame |
| out_eol | output | 1 | Beat is the last pixel of a row |

## Verification
Some rules are checked on every clock cycle. These are the holding of a stalled output beat, the input stall during that time, the binary output values, and the zero value on the frame-start and row-end beats. The correctness of the gradient arithmetic, the strict threshold comparison at equality, the exact beat count per frame, and the correct placement of the markers can only be shown by the bench. It streams flat, step and random images of several sizes with random gaps and back-pressure. It then compares each beat with a model built from the equations.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W  = 8;
    localparam int GRAD_W = 11;
    localparam int MAG_W  = 21;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [GRAD_W-1:0] grad_t;
    typedef logic [MAG_W-1:0]         mag_t;
    // one window column, index 0 is the oldest (top) row
    typedef logic [2:0][PIX_W-1:0]    col_t;

    localparam pix_t EDGE_ON  = 8'hFF;
    localparam pix_t EDGE_OFF = 8'h00;

    // a + 2b + c as a signed value
    function automatic grad_t tri_sum(pix_t a, pix_t b, pix_t c);
        grad_t ea, eb, ec;
        ea = grad_t'({3'b000, a});
        eb = grad_t'({2'b00, b, 1'b0});
        ec = grad_t'({3'b000, c});
        return ea + eb + ec;
    endfunction

endpackage

// File: rtl/sobel_line_store.sv
module sobel_line_store
    import sobel_pkg::*;
#(
    parameter int MAX_W = 64,
    localparam int COL_W = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [COL_W-1:0] col,
    input  pix_t             din,
    output pix_t             older_o,
    output pix_t             newer_o
);
    // newer_mem holds the row just above the incoming one, older_mem the one above that
    pix_t newer_mem [MAX_W];
    pix_t older_mem [MAX_W];

    assign older_o = older_mem[col];
    assign newer_o = newer_mem[col];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            older_mem[col] <= newer_mem[col];
            newer_mem[col] <= din;
        end
    end
endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel
    import sobel_pkg::*;
(
    input  col_t  left,
    input  pix_t  mid_top,
    input  pix_t  mid_bot,
    input  col_t  right,
    input  mag_t  thresh,
    output logic  is_edge
);
    grad_t gx, gy;
    logic signed [MAG_W-1:0] gx_w, gy_w;
    mag_t sq_x, sq_y, mag;

    always_comb begin
        gx   = tri_sum(right[0], right[1], right[2]) - tri_sum(left[0], left[1], left[2]);
        gy   = tri_sum(left[0], mid_top, right[0]) - tri_sum(left[2], mid_bot, right[2]);
        gx_w = MAG_W'(gx);
        gy_w = MAG_W'(gy);
        sq_x = gx_w * gx_w;
        sq_y = gy_w * gy_w;
        mag  = sq_x + sq_y;
        is_edge = (mag > thresh);
    end
endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
    import sobel_pkg::*;
#(
    parameter int MAX_W = 64,
    parameter int MAX_H = 64,
    localparam int WD_W  = $clog2(MAX_W + 1),
    localparam int HT_W  = $clog2(MAX_H + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WD_W-1:0] cfg_width,
    input  logic [HT_W-1:0] cfg_height,
    input  logic [20:0]     cfg_thresh,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_pixel,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [7:0]      out_pixel,
    output logic            out_sof,
    output logic            out_eol
);
    localparam int COL_W = $clog2(MAX_W);
    localparam int ROW_W = $clog2(MAX_H);
    localparam int FL_W  = $clog2(MAX_W + 2);

    typedef struct packed {
        logic [COL_W-1:0] in_col;
        logic [ROW_W-1:0] in_row;
        logic [COL_W-1:0] out_col;
        logic [ROW_W-1:0] out_row;
        logic             flushing;
        logic [FL_W-1:0]  flush_left;
        logic             ov;
        pix_t             opix;
        logic             osof;
        logic             oeol;
        col_t             win_l;
        col_t             win_m;
    } state_t;

    state_t q, d;

    pix_t  lb_older, lb_newer;
    col_t  fresh_col;
    logic  is_edge;
    logic  can_load, take, load, emits, interior;
    logic  in_last_col, in_last_row, out_last_col, out_last_row;
    logic  in_ready_c;

    assign fresh_col = {in_pixel, lb_newer, lb_older};

    sobel_line_store #(.MAX_W(MAX_W)) u_rows (
        .clk     (clk),
        .wr_en   (take),
        .col     (q.in_col),
        .din     (in_pixel),
        .older_o (lb_older),
        .newer_o (lb_newer)
    );

    sobel_kernel u_kern (
        .left    (q.win_l),
        .mid_top (q.win_m[0]),
        .mid_bot (q.win_m[2]),
        .right   (fresh_col),
        .thresh  (cfg_thresh),
        .is_edge (is_edge)
    );

    always_comb begin
        d = q;

        can_load   = !q.ov || out_ready;
        in_ready_c = !q.flushing && can_load;
        take       = in_valid && in_ready_c;

        in_last_col  = (WD_W'(q.in_col)  == cfg_width  - 1'b1);
        in_last_row  = (HT_W'(q.in_row)  == cfg_height - 1'b1);
        out_last_col = (WD_W'(q.out_col) == cfg_width  - 1'b1);
        out_last_row = (HT_W'(q.out_row) == cfg_height - 1'b1);

        // input (R,C) completes the window centred on (R-1,C-1), the output at index -(W+1)
        emits    = (q.in_row != '0) && !((q.in_row == ROW_W'(1)) && (q.in_col == '0));
        interior = (q.in_row >= ROW_W'(2)) && (q.in_col >= COL_W'(2));
        load     = (take && emits) || (q.flushing && can_load);

        if (q.ov && out_ready) begin
            d.ov = 1'b0;
        end

        if (take) begin
            d.win_l = q.win_m;
            d.win_m = fresh_col;
            if (in_last_col) begin
                d.in_col = '0;
                if (in_last_row) begin
                    d.in_row     = '0;
                    d.flushing   = 1'b1;
                    d.flush_left = FL_W'(cfg_width) + FL_W'(1);
                end else begin
                    d.in_row = q.in_row + 1'b1;
                end
            end else begin
                d.in_col = q.in_col + 1'b1;
            end
        end

        if (load) begin
            d.ov   = 1'b1;
            d.opix = (take && interior && is_edge) ? EDGE_ON : EDGE_OFF;
            d.osof = (q.out_row == '0) && (q.out_col == '0);
            d.oeol = out_last_col;
            if (out_last_col) begin
                d.out_col = '0;
                d.out_row = out_last_row ? '0 : q.out_row + 1'b1;
            end else begin
                d.out_col = q.out_col + 1'b1;
            end
        end

        if (q.flushing && can_load) begin
            d.flush_left = q.flush_left - 1'b1;
            if (q.flush_left == FL_W'(1)) begin
                d.flushing = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = in_ready_c;
    assign out_valid = q.ov;
    assign out_pixel = q.opix;
    assign out_sof   = q.osof;
    assign out_eol   = q.oeol;
endmodule

// File: rtl/sobel_edge_stream_chk.sv
module sobel_edge_stream_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_pixel,
    input logic       out_sof,
    input logic       out_eol
);
    a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)
                                       && $stable(out_sof) && $stable(out_eol)));

    a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r9_binary_value: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pixel == 8'h00 || out_pixel == 8'hFF));

    a_r4_sof_is_border: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> (out_pixel == 8'h00 && !out_eol));

    a_r4_eol_is_border: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eol) |-> (out_pixel == 8'h00));
endmodule

bind sobel_edge_stream sobel_edge_stream_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel),
    .out_sof   (out_sof),
    .out_eol   (out_eol)
);

// File: tb/sobel_edge_stream_test.sv
`timescale 1ns/1ps
module sobel_edge_stream_test;
    localparam int MAX_W = 64;
    localparam int MAX_H = 64;
    localparam int TW = 32;
    localparam int TH = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  cfg_width;
    logic [6:0]  cfg_height;
    logic [20:0] cfg_thresh;
    logic        in_valid, in_ready;
    logic [7:0]  in_pixel;
    logic        out_valid, out_ready;
    logic [7:0]  out_pixel;
    logic        out_sof, out_eol;

    int checks = 0;
    int errors = 0;
    int img [TH][TW];

    always #2 clk = ~clk;

    sobel_edge_stream #(.MAX_W(MAX_W), .MAX_H(MAX_H)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_thresh(cfg_thresh), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
        .out_pixel(out_pixel), .out_sof(out_sof), .out_eol(out_eol)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1, R2, R3, R4 reference model
    function automatic int model(int r, int c, int w, int h, longint thr);
        longint gx, gy, m;
        if (r < 1 || r > h - 2 || c < 1 || c > w - 2) return 0;
        gx = (img[r-1][c+1] + 2*img[r][c+1] + img[r+1][c+1])
           - (img[r-1][c-1] + 2*img[r][c-1] + img[r+1][c-1]);
        gy = (img[r-1][c-1] + 2*img[r-1][c] + img[r-1][c+1])
           - (img[r+1][c-1] + 2*img[r+1][c] + img[r+1][c+1]);
        m = gx*gx + gy*gy;
        return (m > thr) ? 255 : 0;
    endfunction

    task automatic fill(int w, int h, int mode, int val);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                case (mode)
                    0: img[r][c] = val;
                    1: img[r][c] = (c >= w/2) ? 255 : 0;
                    default: img[r][c] = int'($urandom % 256);
                endcase
    endtask

    task automatic run_frame(string name, int w, int h, int thr, int rdy_pct, int vld_pct);
        int ii, oi, cyc, r, c, e, err0;
        string req;
        err0 = errors;
        cfg_width  = 7'(w);
        cfg_height = 7'(h);
        cfg_thresh = 21'(thr);
        ii = 0; oi = 0; cyc = 0;
        while ((ii < w*h || oi < w*h) && cyc < 20000) begin
            @(negedge clk);
            out_ready = (($urandom % 100) < rdy_pct);
            if (ii < w*h) begin
                in_valid = (($urandom % 100) < vld_pct);
                in_pixel = 8'(img[ii / w][ii % w]);
            end else begin
                in_valid = 1'b0;
            end
            #0.5;
            if (out_valid && out_ready) begin
                r = oi / w; c = oi % w;
                e = model(r, c, w, h, longint'(thr));
                req = (r >= 1 && r <= h-2 && c >= 1 && c <= w-2) ? "R1 R2 R3" : "R4";
                check(oi < w*h, "R5", {name, " beat beyond frame"}, oi, w*h);
                check(int'(out_pixel) == e, req, $sformatf("%s pixel r=%0d c=%0d", name, r, c),
                      int'(out_pixel), e);
                check(out_pixel == 8'h00 || out_pixel == 8'hFF, "R9", {name, " binary value"},
                      int'(out_pixel), 255);
                check(out_sof == (oi == 0), "R6", $sformatf("%s sof at %0d", name, oi),
                      int'(out_sof), int'(oi == 0));
                check(out_eol == (c == w-1), "R6", $sformatf("%s eol at %0d", name, oi),
                      int'(out_eol), int'(c == w-1));
                oi++;
            end
            if (in_valid && in_ready) ii++;
            cyc++;
        end
        check(ii == w*h, "R5", {name, " inputs accepted"}, ii, w*h);
        check(oi == w*h, "R5", {name, " outputs seen"}, oi, w*h);
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #0.5;
        check(!out_valid, "R5", {name, " no extra beat after frame"}, int'(out_valid), 0);
        check(in_ready, "R8", {name, " ready for next frame"}, int'(in_ready), 1);
        if (rdy_pct < 100)
            check(errors == err0, "R7", {name, " frame intact under back-pressure"}, errors - err0, 0);
        check(errors == err0, "R8", $sformatf("%s frame %0dx%0d clean", name, w, h), errors - err0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_pixel = '0;
        cfg_width = 7'd8; cfg_height = 7'd6; cfg_thresh = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        check(!out_valid, "R10", "out_valid after reset", int'(out_valid), 0);
        check(in_ready, "R10", "in_ready after reset", int'(in_ready), 1);

        // flat image at threshold 0: metric 0 equals threshold, so all zero
        fill(8, 6, 0, 128);
        run_frame("flat", 8, 6, 0, 100, 100);
        // step edge: metric 1040400 at the boundary, equality gives 0
        fill(8, 5, 1, 0);
        run_frame("step_eq", 8, 5, 1040400, 100, 100);
        run_frame("step_gt", 8, 5, 1040399, 80, 90);
        fill(12, 9, 2, 0);
        run_frame("rand_a", 12, 9, 200000, 60, 70);
        fill(32, 7, 2, 0);
        run_frame("rand_bp", 32, 7, 0, 30, 100);
        fill(3, 3, 2, 0);
        run_frame("min3", 3, 3, 1000, 100, 100);
        fill(20, 12, 2, 0);
        run_frame("rand_b", 20, 12, 500000, 100, 50);
        fill(5, 32, 2, 0);
        run_frame("tall", 5, 32, 100000, 50, 50);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule